// File: doc/BRIEF.md
# Audio frame-sync generator

This block produces the bit clock and the frame-sync pulse for a serial audio port. Two programmed fields set the frame length and the width of the active sync pulse. Both are counted in bit clocks, and both are stored as the count minus one. For example, a 16-bit stereo frame uses a period field of 31 and a width field of 15. The bit clock comes from one of two sources. It can be divided down from the system clock, with the block then acting as clock master. Or it can be taken from an external bit-clock pin, in which case the block still drives the frame sync itself.

Each of the two sides, transmit and receive, has two settings. A polarity bit selects whether its sync pin is active high or active low. A mode bit selects whether the side uses the internal generator or an external sync input. Both sides present an active-high sync to the logic that follows.

A small state machine orders the two enables. The states are:
- `GEN_OFF`: everything is stopped.
- `CLK_ONLY`: the bit clock runs but no frame sync is produced.
- `SYNC_RUN`: frames are being produced.

The transitions are:
- `GEN_OFF -> CLK_ONLY` when the generator enable rises without the sync enable.
- `GEN_OFF -> SYNC_RUN` when both enables are set together.
- `CLK_ONLY -> SYNC_RUN` when the sync enable rises.
- `SYNC_RUN -> CLK_ONLY` when the sync enable drops.
- `CLK_ONLY/SYNC_RUN -> GEN_OFF` when the generator enable drops.

Top module: `audio_fsync_gen`

## Requirements
- R1: After reset the state is `GEN_OFF`. In that state `bclk_out` is 0, both side syncs are 0, each sync pin sits at its inactive level (equal to its polarity bit), and each pin enable equals its mode bit.
- R2: In `SYNC_RUN`, each frame lasts `period_m1`+1 bit clocks and frames repeat with no further action. A `period_m1` of 0 gives a frame of one bit clock.
- R3: The generated sync is active for the first `width_m1`+1 bit clocks of each frame. When `width_m1` >= `period_m1`, the width is clipped to the period, so the sync is active for the whole frame.
- R4: With `ext_clk_sel`=0, `bclk_out` toggles every `div_m1`+1 system clocks, so one bit clock lasts 2*(`div_m1`+1) system clocks. A bit is counted on each rising edge of `bclk_out`.
- R5: With `ext_clk_sel`=1, bits are counted on rising edges of `ext_bclk`, taken after a two-stage synchronizer. In this mode `bclk_out` is held at 0 and the frame sync is still produced internally.
- R6: The sync enable has no effect while the generator enable is 0: the sync stays inactive and no bit clock runs. Setting the generator enable afterwards, or together with the sync enable, starts frames.
- R7: Clearing `gen_en` stops `bclk_out` and the sync from the next clock edge. Clearing only `fs_en` stops the sync while `bclk_out` keeps running.
- R8: Each sync pin equals the active-high generated sync XOR its polarity bit, so a polarity bit of 1 means active low. The two sides are independent.
- R9: When a side's mode bit is 1, its pin enable is 1 and its side sync follows the generator. When the mode bit is 0, its pin enable is 0 and its side sync equals its external input XOR its polarity bit; the generator is then not used for that side.
- R10: Changes to `period_m1` and `width_m1` made during `SYNC_RUN` take effect only at the next frame boundary. The current frame completes with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_en | input | 1 | Generator enable |
| fs_en | input | 1 | Frame-sync enable (ignored unless gen_en is set) |
| ext_clk_sel | input | 1 | 1: count bits on ext_bclk; 0: divide the system clock |
| ext_bclk | input | 1 | External bit clock |
| div_m1 | input | DIV_W | Half bit-clock length in system clocks, minus one |
| period_m1 | input | CNT_W | Frame length in bit clocks, minus one |
| width_m1 | input | CNT_W | Active sync width in bit clocks, minus one |
| tx_pol | input | 1 | Transmit sync polarity (1 = active low) |
| rx_pol | input | 1 | Receive sync polarity (1 = active low) |
| tx_fs_int | input | 1 | Transmit sync from the generator (1) or from tx_fs_in (0) |
| rx_fs_int | input | 1 | Receive sync from the generator (1) or from rx_fs_in (0) |
| tx_fs_in | input | 1 | External transmit sync pin level |
| rx_fs_in | input | 1 | External receive sync pin level |
| bclk_out | output | 1 | Generated bit clock |
| tx_fs_out | output | 1 | Transmit sync pin drive level |
| tx_fs_oe | output | 1 | Transmit sync pin drive enable |
| rx_fs_out | output | 1 | Receive sync pin drive level |
| rx_fs_oe | output | 1 | Receive sync pin drive enable |
| tx_sync | output | 1 | Active-high sync seen by the transmit side |
| rx_sync | output | 1 | Active-high sync seen by the receive side |

## Verification
A wrong frame counter or a wrongly latched field changes the fraction of time the sync is active. It also changes the number of sync rising edges in a window of whole frames. Because the sync repeats every frame, this shows up within one frame period in a window of four frames. A wrong divider or wrong edge selection changes the bit length, and so scales every sync count by the same factor. A state-machine error shows on the next clock edge: either the sync or `bclk_out` keeps running after its enable is removed, or one of them starts before the generator is enabled. A field that takes effect too early shows as a wrong width in the pulse during which the field changed.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [1:0] {
        GEN_OFF  = 2'd0,
        CLK_ONLY = 2'd1,
        SYNC_RUN = 2'd2
    } fsg_state_e;
endpackage

// File: rtl/fsg_bit_tick.sv
module fsg_bit_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_sel,
    input  logic             ext_bclk,
    input  logic [DIV_W-1:0] div_m1,
    output logic             bclk_q,
    output logic             tick
);
    localparam int SYNC_D = 3;

    logic [DIV_W-1:0]  hcnt;
    logic [SYNC_D-1:0] ext_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt   <= '0;
            bclk_q <= 1'b0;
            ext_sr <= '0;
        end else begin
            ext_sr <= {ext_sr[SYNC_D-2:0], ext_bclk};
            if (!run || ext_sel) begin
                hcnt   <= '0;
                bclk_q <= 1'b0;
            end else if (hcnt == div_m1) begin
                hcnt   <= '0;
                bclk_q <= !bclk_q;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    always_comb begin
        if (ext_sel)
            tick = run && ext_sr[SYNC_D-2] && !ext_sr[SYNC_D-1];
        else
            tick = run && (hcnt == div_m1) && !bclk_q;
    end

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || ($past(ext_sel) != ext_sel)));

    // R5
    ext_bclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_sel |=> !bclk_q);
endmodule

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr
    import fsg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             fs_en,
    input  logic             tick,
    input  logic [CNT_W-1:0] period_m1,
    input  logic [CNT_W-1:0] width_m1,
    output logic             gen_fs
);
    fsg_state_e       state, next_state;
    logic [CNT_W-1:0] fcnt, lat_p, lat_w;
    logic [CNT_W-1:0] clip_w;
    logic             frame_end;

    assign clip_w    = (width_m1 > period_m1) ? period_m1 : width_m1;
    assign frame_end = tick && (fcnt == lat_p);

    always_comb begin
        next_state = state;
        unique case (state)
            GEN_OFF: begin
                if (gen_en)
                    next_state = fs_en ? SYNC_RUN : CLK_ONLY;
            end
            CLK_ONLY: begin
                if (!gen_en)
                    next_state = GEN_OFF;
                else if (fs_en)
                    next_state = SYNC_RUN;
            end
            SYNC_RUN: begin
                if (!gen_en)
                    next_state = GEN_OFF;
                else if (!fs_en)
                    next_state = CLK_ONLY;
            end
            default: next_state = GEN_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= GEN_OFF;
            fcnt  <= '0;
            lat_p <= '0;
            lat_w <= '0;
        end else begin
            state <= next_state;
            if (next_state != SYNC_RUN) begin
                fcnt <= '0;
            end else if (state != SYNC_RUN) begin
                fcnt  <= '0;
                lat_p <= period_m1;
                lat_w <= clip_w;
            end else if (frame_end) begin
                fcnt  <= '0;
                lat_p <= period_m1;
                lat_w <= clip_w;
            end else if (tick) begin
                fcnt <= fcnt + 1'b1;
            end
        end
    end

    always_comb begin
        gen_fs = (state == SYNC_RUN) && (fcnt <= lat_w);
    end

    // R2
    fcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SYNC_RUN) |-> (fcnt <= lat_p));

    // R3
    width_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SYNC_RUN) |-> (lat_w <= lat_p));

    // R10
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SYNC_RUN && next_state == SYNC_RUN && !frame_end)
            |=> ($stable(lat_p) && $stable(lat_w)));

    // R6
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GEN_OFF && !gen_en) |=> (state == GEN_OFF && !gen_fs));
endmodule

// File: rtl/fsg_side.sv
module fsg_side (
    input  logic gen_fs,
    input  logic pol,
    input  logic int_mode,
    input  logic fs_in,
    output logic fs_out,
    output logic fs_oe,
    output logic sync
);
    always_comb begin
        fs_out = gen_fs ^ pol;
        fs_oe  = int_mode;
        sync   = int_mode ? gen_fs : (fs_in ^ pol);
    end
endmodule

// File: rtl/audio_fsync_gen.sv
module audio_fsync_gen #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             fs_en,
    input  logic             ext_clk_sel,
    input  logic             ext_bclk,
    input  logic [DIV_W-1:0] div_m1,
    input  logic [CNT_W-1:0] period_m1,
    input  logic [CNT_W-1:0] width_m1,
    input  logic             tx_pol,
    input  logic             rx_pol,
    input  logic             tx_fs_int,
    input  logic             rx_fs_int,
    input  logic             tx_fs_in,
    input  logic             rx_fs_in,
    output logic             bclk_out,
    output logic             tx_fs_out,
    output logic             tx_fs_oe,
    output logic             rx_fs_out,
    output logic             rx_fs_oe,
    output logic             tx_sync,
    output logic             rx_sync
);
    localparam int SIDES = 2;

    logic             tick;
    logic             gen_fs;
    logic [SIDES-1:0] pol_v, mode_v, in_v, out_v, oe_v, sync_v;

    fsg_bit_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (gen_en),
        .ext_sel  (ext_clk_sel),
        .ext_bclk (ext_bclk),
        .div_m1   (div_m1),
        .bclk_q   (bclk_out),
        .tick     (tick)
    );

    fsg_frame_ctr #(.CNT_W(CNT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .gen_en    (gen_en),
        .fs_en     (fs_en),
        .tick      (tick),
        .period_m1 (period_m1),
        .width_m1  (width_m1),
        .gen_fs    (gen_fs)
    );

    assign pol_v  = {rx_pol, tx_pol};
    assign mode_v = {rx_fs_int, tx_fs_int};
    assign in_v   = {rx_fs_in, tx_fs_in};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        fsg_side u_side (
            .gen_fs   (gen_fs),
            .pol      (pol_v[s]),
            .int_mode (mode_v[s]),
            .fs_in    (in_v[s]),
            .fs_out   (out_v[s]),
            .fs_oe    (oe_v[s]),
            .sync     (sync_v[s])
        );
    end

    assign tx_fs_out = out_v[0];
    assign rx_fs_out = out_v[1];
    assign tx_fs_oe  = oe_v[0];
    assign rx_fs_oe  = oe_v[1];
    assign tx_sync   = sync_v[0];
    assign rx_sync   = sync_v[1];

    // R7
    gen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (!gen_fs && !bclk_out));
endmodule

// File: tb/audio_fsync_gen_tb.sv
module audio_fsync_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_en = 1'b0, fs_en = 1'b0, ext_clk_sel = 1'b0, ext_bclk;
    logic [7:0] div_m1 = '0, period_m1 = '0, width_m1 = '0;
    logic       tx_pol = 1'b0, rx_pol = 1'b0, tx_fs_int = 1'b1, rx_fs_int = 1'b1;
    logic       tx_fs_in = 1'b0, rx_fs_in = 1'b0;
    logic       bclk_out, tx_fs_out, tx_fs_oe, rx_fs_out, rx_fs_oe, tx_sync, rx_sync;
    int         n_run = 0, n_fail = 0;
    logic       ext_on = 1'b0;
    int         ext_ph = 0;

    always #2.5 clk = ~clk;

    audio_fsync_gen u_dut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .fs_en(fs_en),
        .ext_clk_sel(ext_clk_sel), .ext_bclk(ext_bclk), .div_m1(div_m1),
        .period_m1(period_m1), .width_m1(width_m1), .tx_pol(tx_pol),
        .rx_pol(rx_pol), .tx_fs_int(tx_fs_int), .rx_fs_int(rx_fs_int),
        .tx_fs_in(tx_fs_in), .rx_fs_in(rx_fs_in), .bclk_out(bclk_out),
        .tx_fs_out(tx_fs_out), .tx_fs_oe(tx_fs_oe), .rx_fs_out(rx_fs_out),
        .rx_fs_oe(rx_fs_oe), .tx_sync(tx_sync), .rx_sync(rx_sync)
    );

    // external bit clock: 6 system clocks per bit, 3 high and 3 low
    always @(negedge clk) begin
        if (ext_on) begin
            ext_ph   = (ext_ph == 5) ? 0 : ext_ph + 1;
            ext_bclk = (ext_ph < 3);
        end else begin
            ext_ph   = 0;
            ext_bclk = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int sel);
        case (sel)
            0: return tx_sync;
            1: return rx_sync;
            2: return tx_fs_out;
            3: return rx_fs_out;
            default: return bclk_out;
        endcase
    endfunction

    task automatic measure(input int sel, input int n, output int hi, output int rises);
        logic prev, cur;
        hi = 0; rises = 0;
        prev = pick(sel);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cur = pick(sel);
            if (cur) hi++;
            if (cur && !prev) rises++;
            prev = cur;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frame_check(input string req, input int pm, input int wm,
                               input int bitcyc, input int sel);
        int p, w, hi, rises, exp_r;
        p = pm + 1;
        w = ((wm > pm) ? pm : wm) + 1;
        idle(2 * p * bitcyc + 12);
        measure(sel, 4 * p * bitcyc, hi, rises);
        check(hi == 4 * w * bitcyc, req, hi, 4 * w * bitcyc);
        exp_r = (w < p) ? 4 : 0;
        check(rises == exp_r, req, rises, exp_r);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int hi, rises;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check(bclk_out == 0, "R1 bclk", bclk_out, 0);
        check(tx_sync == 0 && rx_sync == 0, "R1 sync", tx_sync, 0);
        check(tx_fs_out == 0 && tx_fs_oe == 1, "R1 pin", tx_fs_out, 0);

        // R2 R3 sweep of period and width fields, internal clock div 0
        for (int pm = 0; pm < 8; pm++) begin
            for (int wm = 0; wm < 8; wm++) begin
                gen_en = 0; fs_en = 0;
                idle(2);
                period_m1 = pm[7:0]; width_m1 = wm[7:0];
                gen_en = 1; fs_en = 1;
                frame_check("R2/R3 sweep", pm, wm, 2, 0);
            end
        end

        // R4 divider: bclk of 6 clocks, frames scaled
        gen_en = 0; fs_en = 0; idle(2);
        div_m1 = 8'd2; period_m1 = 8'd3; width_m1 = 8'd1;
        gen_en = 1; fs_en = 1;
        idle(20);
        measure(4, 36, hi, rises);
        check(rises == 6, "R4 bclk rises", rises, 6);
        check(hi == 18, "R4 bclk high", hi, 18);
        frame_check("R4 frame", 3, 1, 6, 1);

        // R8 polarity per side
        gen_en = 0; fs_en = 0; idle(2);
        div_m1 = 0; period_m1 = 8'd3; width_m1 = 8'd0;
        tx_pol = 1; rx_pol = 0;
        gen_en = 1; fs_en = 1;
        idle(30);
        measure(2, 32, hi, rises);
        check(hi == 24, "R8 tx active low", hi, 24);
        measure(3, 32, hi, rises);
        check(hi == 8, "R8 rx active high", hi, 8);
        measure(0, 32, hi, rises);
        check(hi == 8, "R8 tx sync", hi, 8);

        // R9 external sync on transmit side
        tx_fs_int = 0; tx_pol = 0; tx_fs_in = 1;
        @(negedge clk);
        check(tx_fs_oe == 0 && rx_fs_oe == 1, "R9 oe", tx_fs_oe, 0);
        check(tx_sync == 1, "R9 ext in", tx_sync, 1);
        tx_fs_in = 0; tx_pol = 1;
        @(negedge clk);
        check(tx_sync == 1, "R9 ext inverted", tx_sync, 1);
        tx_fs_in = 1;
        @(negedge clk);
        check(tx_sync == 0, "R9 ext inverted hi", tx_sync, 0);
        tx_fs_int = 1; tx_pol = 0; tx_fs_in = 0;

        // R7 fs_en off keeps clock, gen_en off stops all
        fs_en = 0;
        idle(3);
        measure(0, 16, hi, rises);
        check(hi == 0, "R7 sync stopped", hi, 0);
        measure(4, 16, hi, rises);
        check(rises == 8, "R7 bclk runs", rises, 8);
        gen_en = 0;
        idle(2);
        measure(4, 16, hi, rises);
        check(hi == 0, "R7 bclk stopped", hi, 0);

        // R6 fs_en alone is ignored, later gen_en starts frames
        fs_en = 1;
        idle(2);
        measure(0, 20, hi, rises);
        check(hi == 0, "R6 no sync", hi, 0);
        measure(4, 20, hi, rises);
        check(hi == 0, "R6 no bclk", hi, 0);
        gen_en = 1;
        frame_check("R6 start", 3, 0, 2, 0);

        // R5 external bit clock
        gen_en = 0; fs_en = 0; idle(2);
        ext_on = 1; ext_clk_sel = 1;
        period_m1 = 8'd3; width_m1 = 8'd1;
        gen_en = 1; fs_en = 1;
        frame_check("R5 ext clock", 3, 1, 6, 0);
        measure(4, 24, hi, rises);
        check(hi == 0, "R5 bclk_out held", hi, 0);

        // R10 field change mid pulse applies at next boundary
        gen_en = 0; fs_en = 0; idle(2);
        ext_on = 0; ext_clk_sel = 0;
        period_m1 = 8'd7; width_m1 = 8'd1;
        gen_en = 1; fs_en = 1;
        idle(40);
        do @(negedge clk); while (tx_sync);
        do @(negedge clk); while (!tx_sync);
        width_m1 = 8'd5;
        hi = 1;
        @(negedge clk);
        while (tx_sync) begin hi++; @(negedge clk); end
        check(hi == 4, "R10 old width kept", hi, 4);
        do @(negedge clk); while (!tx_sync);
        hi = 0;
        while (tx_sync) begin hi++; @(negedge clk); end
        check(hi == 12, "R10 new width", hi, 12);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule